// File: doc/BRIEF.md
# Palette Lookup Table Writer

This block holds a 256-entry colour table for a pixel output path. A processor writes it through byte writes into a 512-byte window on its bus. Each entry is a 12-bit colour with 4 bits each of red, green and blue. Filling one entry takes two writes to adjacent byte addresses. The even address carries red and green as two nibbles, and this pair is held in a staging register. The odd address carries blue and commits the complete colour into the table in one step, so the lookup side never sees a half-written entry.

The pixel side presents an 8-bit index and receives 24-bit RGB one clock later. Each 4-bit component is widened to 8 bits by repeating the nibble in both halves, which is the same as multiplying it by 17.

Top module: `palette_lut`

## Requirements
- R1: After reset every table entry is black, so a lookup of any index returns 24'h000000. The staging register also resets to zero.
- R2: A write whose address lies outside the window changes neither the table nor the staging register. With the defaults the window is 16'h0400 to 16'h05FF.
- R3: Inside the window, the entry number is the offset from the window base shifted right by one. Offset bit 0 selects the even (red/green) write or the odd (blue) write.
- R4: An even write loads red from data bits 7:4 and green from data bits 3:0 into the staging register. It does not change any table entry.
- R5: An odd write stores the staged red and green, together with blue from data bits 3:0, into the selected entry in the same clock.
- R6: On an odd write, data bits 7:4 have no effect.
- R7: The staging register keeps its value after a commit. An odd write that has no even write before it uses whatever red and green were staged last.
- R8: Each component c is widened to the 8-bit value {c,c} (c*17). The output carries red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R9: The lookup is registered. The output reflects the index presented at the previous rising edge, reading the table as it stood before any commit at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 16 | Byte write address |
| wr_data | input | 8 | Byte write data |
| pix_idx | input | 8 | Pixel index for lookup |
| rgb_out | output | 24 | Registered 24-bit colour |

## Verification
The hardest case to reach from the ports is a blue write that arrives with stale staging contents. This happens when an odd write follows another commit, or follows writes that fell outside the window, with no fresh even write in between. The stimulus reaches it in two ways. Directed sequences issue a lone odd write right after a commit and after an out-of-window even-looking write. A long random run draws addresses around and across the window edges, so that unpaired even and odd writes occur often. The bench model tracks the staging register and the table separately and then reads back all 256 entries.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int COMP_W = 4;

  typedef struct packed {
    logic [COMP_W-1:0] r;
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] b;
  } rgb12_t;

  // widen one nibble to a byte by duplicating it (equals c*17)
  function automatic logic [2*COMP_W-1:0] widen(input logic [COMP_W-1:0] c);
    return {c, c};
  endfunction

  function automatic logic [6*COMP_W-1:0] to_rgb24(input rgb12_t e);
    return {widen(e.r), widen(e.g), widen(e.b)};
  endfunction
endpackage

// File: rtl/pal_decode.sv
module pal_decode #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter logic [ADDR_W-1:0] BASE = 16'h0400
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              hit_even,
  output logic              hit_odd,
  output logic [IDX_W-1:0]  idx
);
  localparam int WIN_LOG = IDX_W + 1;

  logic in_win;
  assign in_win   = (wr_addr[ADDR_W-1:WIN_LOG] == BASE[ADDR_W-1:WIN_LOG]);
  assign idx      = wr_addr[WIN_LOG-1:1];
  assign hit_even = wr_en && in_win && !wr_addr[0];
  assign hit_odd  = wr_en && in_win &&  wr_addr[0];
endmodule

// File: rtl/pal_stage.sv
module pal_stage #(
  parameter int COMP_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [2*COMP_W-1:0] din,
  output logic [2*COMP_W-1:0] rg
);
  always_ff @(posedge clk) begin
    if (!rst_n)    rg <= '0;
    else if (load) rg <= din;
  end
endmodule

// File: rtl/pal_store.sv
module pal_store
  import palette_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [IDX_W-1:0] cidx,
  input  rgb12_t           cword,
  input  logic [IDX_W-1:0] pix_idx,
  output logic [23:0]      rgb_out
);
  localparam int ENTRIES = 1 << IDX_W;

  rgb12_t tab [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tab[i] <= '0;
    end else if (commit) begin
      tab[cidx] <= cword;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rgb_out <= '0;
    else        rgb_out <= to_rgb24(tab[pix_idx]);
  end
endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter logic [ADDR_W-1:0] BASE = 16'h0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [23:0]       rgb_out
);
  // named internal events, observed by the bound checker
  logic             stage_load;
  logic             commit;
  logic [IDX_W-1:0] commit_idx;
  logic [7:0]       staged_rg;
  rgb12_t           commit_word;

  pal_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr),
    .hit_even(stage_load), .hit_odd(commit), .idx(commit_idx)
  );

  pal_stage #(.COMP_W(COMP_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .load(stage_load), .din(wr_data), .rg(staged_rg)
  );

  // high nibble of the blue write is dropped here
  assign commit_word = '{r: staged_rg[7:4], g: staged_rg[3:0], b: wr_data[3:0]};

  pal_store #(.IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .cidx(commit_idx),
    .cword(commit_word), .pix_idx(pix_idx), .rgb_out(rgb_out)
  );
endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter logic [ADDR_W-1:0] BASE = 16'h0400
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [IDX_W-1:0]  pix_idx,
  input logic [23:0]       rgb_out,
  input logic              commit,
  input logic              stage_load,
  input logic [IDX_W-1:0]  commit_idx
);
  localparam int WIN_BYTES = 2 << IDX_W;
  localparam logic [ADDR_W:0] LO = {1'b0, BASE};
  localparam logic [ADDR_W:0] HI = LO + WIN_BYTES;

  logic outside;
  assign outside = ({1'b0, wr_addr} < LO) || ({1'b0, wr_addr} >= HI);

  assert_reset_black_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rgb_out == 24'h0);

  assert_outside_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && outside) |-> !(commit || stage_load));

  assert_even_no_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stage_load |-> !commit);

  assert_even_keeps_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_load && !$past(commit) && $stable(pix_idx)) |=> $stable(rgb_out));

  assert_blue_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit ##1 (pix_idx == $past(commit_idx)))
      |=> rgb_out[7:0] == {$past(wr_data[3:0], 2), $past(wr_data[3:0], 2)});

  assert_nibble_dup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_out[23:20] == rgb_out[19:16]) && (rgb_out[15:12] == rgb_out[11:8])
      && (rgb_out[7:4] == rgb_out[3:0]));
endmodule

bind palette_lut palette_lut_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .pix_idx(pix_idx), .rgb_out(rgb_out), .commit(commit), .stage_load(stage_load),
  .commit_idx(commit_idx)
);

// File: tb/palette_lut_bench.sv
module palette_lut_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  pix_idx = '0;
  logic [23:0] rgb_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [11:0] m_tab [256];
  logic [7:0]  m_rg;

  palette_lut u_palette_lut (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] x17(input logic [3:0] c);
    return 8'(c * 17);
  endfunction

  function automatic logic [23:0] m_rgb(input logic [11:0] e);
    return {x17(e[11:8]), x17(e[7:4]), x17(e[3:0])};
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %06h expected %06h", req, act, exp);
    end
  endtask

  // model: window 0x0400..0x05FF
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    if (a >= 16'h0400 && a < 16'h0600) begin
      if (!a[0]) m_rg = d;
      else m_tab[8'((a - 16'h0400) >> 1)] = {m_rg, d[3:0]};
    end
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input string req, input logic [7:0] i);
    @(negedge clk);
    pix_idx = i;
    @(posedge clk);
    #1 check(req, rgb_out, m_rgb(m_tab[i]));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_tab[i] = '0;
    m_rg = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset state
    look("R1", 8'd0); look("R1", 8'd128); look("R1", 8'd255);

    // R3 R5 R8: basic pair into entry 0x12
    bus_write(16'h0424, 8'hA5); bus_write(16'h0425, 8'h03);
    look("R5", 8'h12);
    check("R8", rgb_out, 24'hAA5533);
    // R3: boundary entries
    bus_write(16'h0400, 8'h1F); bus_write(16'h0401, 8'h0E); look("R3", 8'd0);
    bus_write(16'h05FE, 8'hC3); bus_write(16'h05FF, 8'h07); look("R3", 8'd255);

    // R4: even write alone leaves the entry unchanged
    bus_write(16'h0424, 8'h00); look("R4", 8'h12);
    check("R4", rgb_out, 24'hAA5533);

    // R6: high nibble on blue write ignored
    bus_write(16'h0431, 8'hF9); look("R6", 8'h18);
    check("R6", rgb_out, 24'h000099);

    // R7: lone odd write reuses staged red/green
    bus_write(16'h0440, 8'h6B); bus_write(16'h0441, 8'h01);
    bus_write(16'h0443, 8'h02); look("R7", 8'h21);
    check("R7", rgb_out, 24'h66BB22);

    // R2: writes outside the window
    bus_write(16'h03FE, 8'hFF); bus_write(16'h03FF, 8'h0F);
    bus_write(16'h0600, 8'h77); bus_write(16'h0601, 8'h0C);
    look("R2", 8'd255); look("R2", 8'd0);
    bus_write(16'h0445, 8'h04); look("R2", 8'h22);
    check("R2", rgb_out, 24'h66BB44);

    // R9: output follows index one clock later
    look("R9", 8'h12);
    @(negedge clk) pix_idx = 8'h21;
    check("R9", rgb_out, 24'hAA5533);
    @(posedge clk); #1 check("R9", rgb_out, 24'h66BB22);

    // random traffic around the window, then full readback
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] a;
      a = 16'h0300 + 16'($urandom_range(0, 16'h03FF));
      bus_write(a, 8'($urandom));
    end
    for (int i = 0; i < 256; i++) look("R5", 8'(i));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion"); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule